// File: doc/BRIEF.md
# Write-Merging Store Buffer

This block sits between a processor store port and the write half of an AXI interface whose data bus is 64 bits wide. Each incoming store is a byte, halfword or word, carries its byte address and data in the low lanes of a 32-bit word, and is flagged as either strongly ordered/device or normal memory.

Normal-memory stores collect in a small entry table, one entry per aligned doubleword. A later store to the same doubleword merges into the existing entry, and its bytes replace older ones. When the table drains, all normal entries that lie in one 32-byte aligned block leave as a single 64-bit INCR burst. The burst runs from the lowest occupied doubleword to the highest, and a doubleword between them that holds no data goes out as a beat with every strobe low. Bursts may therefore leave in a different order from the stores.

An ordered or device store never merges. It waits until every older entry has been written and acknowledged. It then leaves as its own single-beat INCR burst, with the store's address and a beat size equal to the access size. The buffer drains when a store misses while the table is full, when an ordered store arrives, or when the flush input is raised. A done output reports that the buffer is empty and no response is outstanding.

Top module: `wmerge_sbuf`

## Requirements
- R1: Strobe bit n enables byte lane n of the aligned doubleword, and write data sits in the lanes of its address. A halfword at offset 0x18 gives strobes 0x03, a word at offset 0x0C gives 0xF0, and a byte at offset 0x1D gives 0x20.
- R2: An ordered store (st_dev=1) leaves as one burst of exactly one beat. awaddr equals the store's byte address, awlen is 0, and awsize equals st_size (0 byte, 1 halfword, 2 word).
- R3: An ordered store is accepted only when the table is empty and no burst is outstanding. While older entries remain, st_ready is low, and their bursts are issued before the ordered store's burst.
- R4: Normal stores (st_dev=0) to the same doubleword share one entry and produce one beat. The bytes of the newest store replace older bytes, and a fully overwritten store never appears on the bus.
- R5: The normal entries in one 32-byte aligned block leave as one burst with awsize=3. awaddr is the lowest occupied doubleword, awlen is the highest occupied doubleword offset minus the lowest, and unoccupied doublewords in that range carry wstrb=0. A burst never crosses a 32-byte boundary.
- R6: awburst is always 2'b01 (INCR). wlast is high on the final beat of a burst and on no other beat.
- R7: The table holds four entries. While it is full, a normal store to a doubleword already held is still accepted and merged. A store that misses is held off with st_ready low while the whole table drains, and is then accepted.
- R8: A flush pulse drains every entry. flush_done is low while any entry is held or a burst is outstanding, and it is high otherwise.
- R9: Every accepted address is followed by exactly awlen+1 data beats. The write response is awaited before the next address is issued, and awvalid holds with a stable address until it is accepted.
- R10: After reset the table is empty, flush_done is 1, st_ready is 1 and awvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted on this cycle when valid |
| st_addr | input | AW | Store byte address, naturally aligned |
| st_size | input | 2 | 0 byte, 1 halfword, 2 word |
| st_data | input | 32 | Store data, right-justified |
| st_dev | input | 1 | 1 = ordered/device memory, 0 = normal memory |
| flush | input | 1 | Request to drain all entries |
| flush_done | output | 1 | Buffer empty and nothing outstanding |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address accepted |
| awaddr | output | AW | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Beat size code |
| awburst | output | 2 | Burst type, always INCR |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data accepted |
| wdata | output | 64 | Write data |
| wstrb | output | 8 | Byte strobes |
| wlast | output | 1 | Final beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Ready for write response |

## Verification
The properties assume that stores are naturally aligned, that st_size never takes the value 3, and that a store request keeps its fields unchanged until it is accepted. They also assume the responder returns exactly one write response per burst, and only after that burst's last beat. The stimulus issues only aligned byte, halfword and word stores and holds each request until st_ready is seen. It models a responder whose address and data ready signals stall in a fixed rhythm, and which answers once, a few cycles after each wlast.

// File: rtl/wmerge_sbuf.sv
module wmerge_sbuf #(
  parameter int AW = 32,
  parameter int NE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [31:0]   st_data,
  input  logic          st_dev,
  input  logic          flush,
  output logic          flush_done,
  output logic          awvalid,
  input  logic          awready,
  output logic [AW-1:0] awaddr,
  output logic [7:0]    awlen,
  output logic [2:0]    awsize,
  output logic [1:0]    awburst,
  output logic          wvalid,
  input  logic          wready,
  output logic [63:0]   wdata,
  output logic [7:0]    wstrb,
  output logic          wlast,
  input  logic          bvalid,
  output logic          bready
);
  localparam int DW = AW - 3;
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;

  typedef enum logic [1:0] {IDLE, ADDR, DATA, RESP} phase_t;

  logic [NE-1:0] ent_v, ent_dev;
  logic [DW-1:0] ent_dw   [NE];
  logic [2:0]    ent_lo   [NE];
  logic [1:0]    ent_sz   [NE];
  logic [63:0]   ent_data [NE];
  logic [7:0]    ent_msk  [NE];

  phase_t        phase;
  logic          drain_q;
  logic [NE-1:0] b_sel;
  logic [DW-1:0] b_dw;
  logic [1:0]    b_len, beat;
  logic          b_dev;
  logic [2:0]    b_lo;
  logic [1:0]    b_sz;

  logic [DW-1:0] st_dw, cur_dw;
  logic [7:0]    st_msk;
  logic [63:0]   st_wd, st_bm;
  logic          hit, any_v, can_take, accept, need_drain, wr_new;
  logic [IW-1:0] hit_idx, free_idx, lead, wr_idx;
  logic [NE-1:0] grp;
  logic [3:0]    pres;
  logic [1:0]    lo_k, hi_k;

  assign st_dw  = st_addr[AW-1:3];
  assign st_msk = ((st_size == 2'd0) ? 8'h01 : (st_size == 2'd1) ? 8'h03 : 8'h0F) << st_addr[2:0];
  assign st_wd  = {32'b0, st_data} << {st_addr[2:0], 3'b000};

  always_comb
    for (int k = 0; k < 8; k++) st_bm[8*k +: 8] = {8{st_msk[k]}};

  always_comb begin
    hit = 1'b0; hit_idx = '0; free_idx = '0; lead = '0;
    for (int i = NE-1; i >= 0; i--) begin
      if (ent_v[i] && !ent_dev[i] && ent_dw[i] == st_dw) begin
        hit = 1'b1; hit_idx = IW'(i);
      end
      if (!ent_v[i]) free_idx = IW'(i);
      if (ent_v[i])  lead = IW'(i);
    end
  end

  always_comb begin
    grp = '0; pres = '0; lo_k = '0; hi_k = '0;
    for (int i = 0; i < NE; i++)
      if (ent_v[i] && !ent_dev[i] && ent_dw[i][DW-1:2] == ent_dw[lead][DW-1:2]) begin
        grp[i] = 1'b1;
        pres[ent_dw[i][1:0]] = 1'b1;
      end
    for (int k = 3; k >= 0; k--) if (pres[k]) lo_k = 2'(k);
    for (int k = 0; k < 4; k++)  if (pres[k]) hi_k = 2'(k);
  end

  assign any_v      = |ent_v;
  assign can_take   = st_dev ? !any_v : (hit || !(&ent_v));
  assign st_ready   = !drain_q && can_take;
  assign accept     = st_valid && st_ready;
  assign need_drain = flush || (st_valid && (st_dev || !can_take));
  assign wr_new     = st_dev || !hit;
  assign wr_idx     = wr_new ? free_idx : hit_idx;
  assign flush_done = !any_v && phase == IDLE;

  always_ff @(posedge clk)
    if (accept) begin
      ent_dw[wr_idx]   <= st_dw;
      ent_lo[wr_idx]   <= st_addr[2:0];
      ent_sz[wr_idx]   <= st_size;
      ent_data[wr_idx] <= wr_new ? st_wd : ((ent_data[wr_idx] & ~st_bm) | (st_wd & st_bm));
      ent_msk[wr_idx]  <= wr_new ? st_msk : (ent_msk[wr_idx] | st_msk);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ent_v <= '0; ent_dev <= '0; drain_q <= 1'b0; phase <= IDLE;
      b_sel <= '0; b_dw <= '0; b_len <= '0; beat <= '0;
      b_dev <= 1'b0; b_lo <= '0; b_sz <= '0;
    end else begin
      if (!drain_q)                      drain_q <= need_drain;
      else if (phase == IDLE && !any_v)  drain_q <= 1'b0;
      if (accept) begin
        ent_v[wr_idx]   <= 1'b1;
        ent_dev[wr_idx] <= st_dev;
      end
      case (phase)
        IDLE: if (drain_q && any_v) begin
          b_dev <= ent_dev[lead];
          b_lo  <= ent_lo[lead];
          b_sz  <= ent_sz[lead];
          b_sel <= ent_dev[lead] ? (NE'(1) << lead) : grp;
          b_dw  <= ent_dev[lead] ? ent_dw[lead] : {ent_dw[lead][DW-1:2], lo_k};
          b_len <= ent_dev[lead] ? 2'd0 : hi_k - lo_k;
          phase <= ADDR;
        end
        ADDR: if (awready) begin beat <= '0; phase <= DATA; end
        DATA: if (wready) begin
          if (beat == b_len) phase <= RESP;
          else               beat <= beat + 2'd1;
        end
        RESP: if (bvalid) begin
          ent_v <= ent_v & ~b_sel;
          phase <= IDLE;
        end
        default: phase <= IDLE;
      endcase
    end

  assign cur_dw  = b_dw + DW'(beat);
  assign awvalid = phase == ADDR;
  assign awaddr  = b_dev ? {b_dw, b_lo} : {b_dw, 3'b000};
  assign awsize  = b_dev ? {1'b0, b_sz} : 3'd3;
  assign awlen   = {6'b0, b_len};
  assign awburst = 2'b01;
  assign wvalid  = phase == DATA;
  assign wlast   = beat == b_len;
  assign bready  = phase == RESP;

  always_comb begin
    wdata = '0; wstrb = '0;
    for (int i = 0; i < NE; i++)
      if (b_sel[i] && ent_dw[i] == cur_dw) begin
        wdata = ent_data[i];
        wstrb = ent_msk[i];
      end
  end
endmodule

module wmerge_sbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       st_valid,
  input logic       st_ready,
  input logic       flush_done,
  input logic       awvalid,
  input logic       awready,
  input logic [4:0] awaddr_lo,
  input logic [7:0] awlen,
  input logic [2:0] awsize,
  input logic       wvalid,
  input logic       wready,
  input logic       wlast,
  input logic [7:0] wstrb,
  input logic       bready
);
  a_r9_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr_lo) && $stable(awlen));

  a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awsize == 3'd3 |-> awaddr_lo[2:0] == 3'd0 && awlen[7:2] == 6'd0 &&
      ({1'b0, awaddr_lo[4:3]} + {1'b0, awlen[1:0]}) <= 3'd3);

  a_r2_dev_single: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awsize != 3'd3 |-> awlen == 8'd0);

  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && wready && wlast |=> !wvalid && bready);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !awvalid && !wvalid && !bready);

  a_r3_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready |-> !awvalid && !wvalid && !bready);

  a_r1_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && awsize == 3'd0 |-> $countones(wstrb) == 1);
endmodule

bind wmerge_sbuf wmerge_sbuf_chk u_wmerge_sbuf_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .flush_done(flush_done), .awvalid(awvalid), .awready(awready),
  .awaddr_lo(awaddr[4:0]), .awlen(awlen), .awsize(awsize),
  .wvalid(wvalid), .wready(wready), .wlast(wlast), .wstrb(wstrb), .bready(bready)
);

// File: tb/test_wmerge_sbuf.sv
`timescale 1ns/1ps
module test_wmerge_sbuf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, st_dev = 1'b0, flush = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [1:0] st_size = '0;
  logic st_ready, flush_done, awvalid, wvalid, wlast, bready;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [31:0] awaddr;
  logic [7:0] awlen, wstrb;
  logic [2:0] awsize;
  logic [1:0] awburst;
  logic [63:0] wdata;

  always #2.5 clk = ~clk;

  wmerge_sbuf i_wmerge_sbuf (
    .clk, .rst_n, .st_valid, .st_ready, .st_addr, .st_size, .st_data, .st_dev,
    .flush, .flush_done, .awvalid, .awready, .awaddr, .awlen, .awsize, .awburst,
    .wvalid, .wready, .wdata, .wstrb, .wlast, .bvalid, .bready
  );

  logic [31:0] la_addr [256];
  logic [7:0]  la_len  [256];
  logic [2:0]  la_size [256];
  logic [1:0]  la_bt   [256];
  int          la_wb   [256];
  logic [63:0] lw_data [1024];
  logic [7:0]  lw_strb [1024];
  logic        lw_last [1024];
  int naw = 0, nw = 0, cyc = 0, bdly = 0;
  int errs = 0, nchk = 0;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    awready <= (cyc % 3) != 1;
    wready  <= (cyc % 4) != 2;
    if (awvalid && awready) begin
      la_addr[naw] <= awaddr; la_len[naw] <= awlen; la_size[naw] <= awsize;
      la_bt[naw] <= awburst; la_wb[naw] <= nw; naw <= naw + 1;
    end
    if (wvalid && wready) begin
      lw_data[nw] <= wdata; lw_strb[nw] <= wstrb; lw_last[nw] <= wlast; nw <= nw + 1;
    end
    if (wvalid && wready && wlast) bdly <= 3;
    else if (bdly > 0) bdly <= bdly - 1;
    if (bdly == 1) bvalid <= 1'b1;
    else if (bvalid && bready) bvalid <= 1'b0;
  end

  function automatic logic [63:0] bexp(logic [7:0] s);
    for (int k = 0; k < 8; k++) bexp[8*k +: 8] = {8{s[k]}};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic store(logic [31:0] a, logic [1:0] sz, logic [31:0] d, logic dv);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d; st_dev = dv;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!flush_done) @(negedge clk);
  endtask

  task automatic do_flush(bit busy);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    if (busy) chk("R8 done low while draining", flush_done, 1'b0);
    while (!flush_done) @(negedge clk);
    chk("R8 quiet when done", {awvalid, wvalid, bready}, 3'b000);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 st_ready", st_ready, 1'b1);
    chk("R10 flush_done", flush_done, 1'b1);
    chk("R10 awvalid", awvalid, 1'b0);

    // R2 R1: ordered stores, every size and lane
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 8; off += (1 << sz)) begin
        logic [31:0] a, d;
        logic [7:0] es;
        a = 32'h1000 + off;
        d = 32'hA1B2C3D4 ^ (off * 32'h01010101);
        es = 8'(((1 << (1 << sz)) - 1) << off);
        b0 = naw;
        store(a, 2'(sz), d, 1'b1);
        wait_idle();
        chk("R2 one burst", naw - b0, 1);
        chk("R2 addr", la_addr[b0], a);
        chk("R2 size", la_size[b0], sz);
        chk("R2 len", la_len[b0], 0);
        chk("R1 strobe", lw_strb[la_wb[b0]], es);
        chk("R1 data", lw_data[la_wb[b0]] & bexp(es), ({32'b0, d} << (8 * off)) & bexp(es));
        chk("R6 last", lw_last[la_wb[b0]], 1'b1);
        chk("R6 incr", la_bt[b0], 2'b01);
      end

    // R3: ordered store waits behind a normal entry
    b0 = naw;
    store(32'h2008, 2'd2, 32'h55667788, 1'b0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h3004; st_size = 2'd2; st_data = 32'h99AABBCC; st_dev = 1'b1;
    #1;
    chk("R3 held off", st_ready, 1'b0);
    store(32'h3004, 2'd2, 32'h99AABBCC, 1'b1);
    wait_idle();
    chk("R3 two bursts", naw - b0, 2);
    chk("R3 older first", la_addr[b0], 32'h2008);
    chk("R3 older size", la_size[b0], 3);
    chk("R3 ordered second", la_addr[b0+1], 32'h3004);
    chk("R1 word hi strobe", lw_strb[la_wb[b0+1]], 8'hF0);

    // R4 R5 R1: merged normal sequence in one 32-byte block
    b0 = naw;
    store(32'h4018, 2'd1, 32'h0000CAFE, 1'b0);
    store(32'h400C, 2'd2, 32'h11111111, 1'b0);
    store(32'h4000, 2'd2, 32'hA0A0A0A0, 1'b0);
    store(32'h4004, 2'd2, 32'hB1B1B1B1, 1'b0);
    store(32'h4008, 2'd2, 32'hC2C2C2C2, 1'b0);
    store(32'h400C, 2'd2, 32'hD3D3D3D3, 1'b0);
    store(32'h401D, 2'd0, 32'h0000005A, 1'b0);
    chk("R4 no drain yet", naw - b0, 0);
    do_flush(1'b1);
    chk("R5 one burst", naw - b0, 1);
    chk("R5 addr", la_addr[b0], 32'h4000);
    chk("R5 len", la_len[b0], 3);
    chk("R5 size", la_size[b0], 3);
    chk("R5 strobe 0", lw_strb[la_wb[b0]], 8'hFF);
    chk("R5 strobe 1", lw_strb[la_wb[b0]+1], 8'hFF);
    chk("R5 gap strobe", lw_strb[la_wb[b0]+2], 8'h00);
    chk("R1 merged strobe", lw_strb[la_wb[b0]+3], 8'h23);
    chk("R4 data 0", lw_data[la_wb[b0]], 64'hB1B1B1B1A0A0A0A0);
    chk("R4 overwrite", lw_data[la_wb[b0]+1], 64'hD3D3D3D3C2C2C2C2);
    chk("R4 merged data", lw_data[la_wb[b0]+3] & bexp(8'h23), 64'h00005A000000CAFE);
    chk("R6 last flags", {lw_last[la_wb[b0]], lw_last[la_wb[b0]+1], lw_last[la_wb[b0]+2], lw_last[la_wb[b0]+3]}, 4'b0001);

    // R4: partial overwrite inside a word
    b0 = naw;
    store(32'h6000, 2'd2, 32'h11223344, 1'b0);
    store(32'h6001, 2'd0, 32'h000000AB, 1'b0);
    do_flush(1'b1);
    chk("R4 single beat", la_len[b0], 0);
    chk("R4 strobe", lw_strb[la_wb[b0]], 8'h0F);
    chk("R4 byte replaced", lw_data[la_wb[b0]][31:0], 32'h1122AB44);

    // R5: every occupancy pattern of one block
    for (int s = 1; s < 16; s++) begin
      int lo, hi;
      lo = 4; hi = 0; b0 = naw;
      for (int k = 0; k < 4; k++)
        if (s[k]) begin
          store(32'h8000 + s*32 + k*9, 2'd0, 32'h10 + k, 1'b0);
          if (lo == 4) lo = k;
          hi = k;
        end
      do_flush(1'b1);
      chk("R5 sweep one burst", naw - b0, 1);
      chk("R5 sweep addr", la_addr[b0], 32'h8000 + s*32 + lo*8);
      chk("R5 sweep len", la_len[b0], hi - lo);
      for (int k = lo; k <= hi; k++) begin
        chk("R5 sweep strobe", lw_strb[la_wb[b0] + k - lo], s[k] ? 8'(1 << k) : 8'h00);
        if (s[k]) chk("R1 sweep lane", lw_data[la_wb[b0] + k - lo][8*k +: 8], 8'(8'h10 + k));
      end
    end

    // R5: neighbours across a 32-byte boundary stay apart
    b0 = naw;
    store(32'h7018, 2'd2, 32'h01020304, 1'b0);
    store(32'h7020, 2'd2, 32'h05060708, 1'b0);
    do_flush(1'b1);
    chk("R5 boundary bursts", naw - b0, 2);
    chk("R5 boundary first", la_addr[b0], 32'h7018);
    chk("R5 boundary lens", {la_len[b0], la_len[b0+1]}, 16'h0000);

    // R7: full table
    b0 = naw;
    for (int i = 0; i < 4; i++) store(32'h9000 + i*32'h40, 2'd2, 32'hC0DE0000 + i, 1'b0);
    store(32'h9004, 2'd2, 32'hFEEDF00D, 1'b0);
    chk("R7 hit while full", naw - b0, 0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h9100; st_size = 2'd2; st_data = 32'h12345678; st_dev = 1'b0;
    #1;
    chk("R7 miss held off", st_ready, 1'b0);
    store(32'h9100, 2'd2, 32'h12345678, 1'b0);
    chk("R7 drained before accept", naw - b0, 4);
    chk("R7 merged data", lw_data[la_wb[b0]], 64'hFEEDF00DC0DE0000);
    do_flush(1'b1);
    chk("R7 last entry", naw - b0, 5);
    chk("R7 last addr", la_addr[b0+4], 32'h9100);

    // R8: flush of an empty buffer
    do_flush(1'b0);
    chk("R8 empty stays done", flush_done, 1'b1);

    // R9: beats per burst
    for (int j = 0; j + 1 < naw; j++)
      chk("R9 beat count", la_wb[j+1] - la_wb[j], la_len[j] + 1);
    chk("R9 total beats", nw - la_wb[naw-1], la_len[naw-1] + 1);

    finish_up();
  end
endmodule